// File: doc/BRIEF.md
# Four-Mode Bit-Sliced Register

This block is a small synchronous register. On each rising clock edge it performs one of four operations, chosen by a two-bit mode input:

- hold the stored value;
- take a word from the parallel data input;
- invert every stored bit in place;
- shift the word one place toward the most significant bit, with a serial fill bit entering at bit 0.

A synchronous active-high reset clears the word and takes precedence over every mode.

The storage is a chain of identical one-bit slices. Each slice holds one D flip-flop. Its next-state input is a sum of products formed from:

- the decoded mode strobes;
- its own parallel data bit;
- its own stored bit;
- the stored bit of the slice below it.

Each slice drives both its stored bit and the complement of that bit. A small control module decodes the mode into a one-hot strobe struct that is shared by all slices.

Top module: `multiModeReg`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, every bit of `qOut` becomes 0, whatever the values of `modeSel`, `parData` and `serialIn`.
- R2: With `modeSel` = 2'b00 at a rising edge, `qOut` keeps its previous value.
- R3: With `modeSel` = 2'b01 at a rising edge, `qOut` takes the value of `parData`.
- R4: With `modeSel` = 2'b10 at a rising edge, every bit of `qOut` takes the inverse of its previous value.
- R5: With `modeSel` = 2'b11 at a rising edge, bit i of `qOut` (i ≥ 1) takes the previous bit i-1, bit 0 takes `serialIn`, and the previous bit 3 is lost.
- R6: At all times `qOutN` is the bitwise inverse of `qOut`.
- R7: `serialIn` has no effect on `qOut` in any mode other than 2'b11.
- R8: `parData` has no effect on `qOut` in any mode other than 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the word |
| modeSel | input | 2 | Operation: 00 hold, 01 load, 10 invert, 11 shift left |
| parData | input | 4 | Word loaded in mode 01 |
| serialIn | input | 1 | Bit entering position 0 during shift left |
| qOut | output | 4 | Stored word |
| qOutN | output | 4 | Bitwise complement of the stored word |

## Verification
The hardest case to reach from the ports is a shift that has to discard a 1 from bit 3. It also has to place a chosen fill bit at bit 0 right after an invert or a load, so that the neighbour chaining and the dropped top bit are both visible.

The stimulus reaches it in two ways. Directed sequences load a pattern, invert it, and then shift several times with alternating fill bits. A long pseudo-random run then mixes all four modes, resets asserted with other modes active, and random data and fill values that are present while they must be ignored. A behavioural model of the register is compared with both outputs on every clock.

// File: rtl/multiModeReg_pkg.sv
package multiModeReg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_LOAD   = 2'b01,
    MODE_INVERT = 2'b10,
    MODE_SHIFT  = 2'b11
  } modeT;

  typedef struct packed {
    logic doHold;
    logic doLoad;
    logic doInvert;
    logic doShift;
  } strobeT;

endpackage

// File: rtl/multiModeRegCtrl.sv
module multiModeRegCtrl
  import multiModeReg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  output strobeT     strobes
);

  modeT modeVal;

  always_comb begin
    modeVal = modeT'(modeSel);
    strobes = '0;
    unique case (modeVal)
      MODE_HOLD:   strobes.doHold   = 1'b1;
      MODE_LOAD:   strobes.doLoad   = 1'b1;
      MODE_INVERT: strobes.doInvert = 1'b1;
      MODE_SHIFT:  strobes.doShift  = 1'b1;
      default:     strobes.doHold   = 1'b1;
    endcase
  end

  // R2..R5: each mode code selects exactly one operation
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(strobes));

endmodule

// File: rtl/multiModeRegSlice.sv
module multiModeRegSlice
  import multiModeReg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strobeT strobes,
  input  logic   dataBit,
  input  logic   lowerBit,
  output logic   qBit,
  output logic   qBitN
);

  logic nextBit;

  // sum of products feeding the single flip-flop
  always_comb begin
    nextBit = (strobes.doHold   &  qBit)
            | (strobes.doLoad   &  dataBit)
            | (strobes.doInvert & ~qBit)
            | (strobes.doShift  &  lowerBit);
  end

  always_ff @(posedge clk) begin
    if (rst) qBit <= 1'b0;
    else     qBit <= nextBit;
  end

  assign qBitN = ~qBit;

endmodule

// File: rtl/multiModeRegDatapath.sv
module multiModeRegDatapath
  import multiModeReg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobeT           strobes,
  input  logic [WIDTH-1:0] parData,
  input  logic             serialIn,
  output logic [WIDTH-1:0] qWord,
  output logic [WIDTH-1:0] qWordN
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0] chain;

  assign chain[0] = serialIn;

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    multiModeRegSlice uSlice (
      .clk      (clk),
      .rst      (rst),
      .strobes  (strobes),
      .dataBit  (parData[i]),
      .lowerBit (chain[i]),
      .qBit     (qWord[i]),
      .qBitN    (qWordN[i])
    );
    assign chain[i+1] = qWord[i];
  end

  logic topUnused;
  assign topUnused = chain[TOP+1];

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.doHold |=> $stable(qWord));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.doLoad |=> qWord == $past(parData));

  assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.doInvert |=> qWord == ~$past(qWord));

  assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.doShift |=> qWord == {$past(qWord[TOP-1:0]), $past(serialIn)});

endmodule

// File: rtl/multiModeReg.sv
module multiModeReg
  import multiModeReg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] parData,
  input  logic             serialIn,
  output logic [WIDTH-1:0] qOut,
  output logic [WIDTH-1:0] qOutN
);

  strobeT strobes;

  multiModeRegCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .strobes (strobes)
  );

  multiModeRegDatapath #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .parData  (parData),
    .serialIn (serialIn),
    .qWord    (qOut),
    .qWordN   (qOutN)
  );

  logic seenEdge;

  always_ff @(posedge clk) begin
    seenEdge <= 1'b1;
    if (seenEdge && $past(rst)) begin
      assert_reset_clear_R1: assert (qOut == '0);
    end
  end

  always @(negedge clk) begin
    if (seenEdge) begin
      assert_complement_R6: assert (qOutN == ~qOut);
    end
  end

endmodule

// File: tb/tb_multiModeReg.sv
module tb_multiModeReg;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b01;
  logic [3:0] parData = 4'hF;
  logic       serialIn = 1'b1;
  logic [3:0] qOut;
  logic [3:0] qOutN;

  int checks = 0;
  int errors = 0;
  int expWord = 0;
  string lastTag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multiModeReg dut (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .parData  (parData),
    .serialIn (serialIn),
    .qOut     (qOut),
    .qOutN    (qOutN)
  );

  task automatic checkOut();
    checks++;
    if (qOut !== expWord[3:0]) begin
      errors++;
      $display("FAIL %s: qOut=%b expected %b", lastTag, qOut, expWord[3:0]);
    end
    checks++;
    if (qOutN !== ~expWord[3:0]) begin
      errors++;
      $display("FAIL R6: qOutN=%b expected %b", qOutN, ~expWord[3:0]);
    end
  endtask

  // apply one cycle: check result of previous cycle, drive new inputs, update model
  task automatic step(input bit r, input bit [1:0] m, input bit [3:0] d, input bit s);
    @(negedge clk);
    checkOut();
    rst = r; modeSel = m; parData = d; serialIn = s;
    if (r) begin
      expWord = 0; lastTag = "R1";
    end else begin
      case (m)
        2'b00: lastTag = s ? "R2/R7" : "R2/R8";
        2'b01: begin expWord = d; lastTag = "R3/R7"; end
        2'b10: begin expWord = (~expWord) & 15; lastTag = "R4/R7/R8"; end
        default: begin expWord = ((expWord << 1) | s) & 15; lastTag = "R5/R8"; end
      endcase
    end
  endtask

  initial begin
    // R1: reset with load mode and all-ones inputs still clears
    step(1, 2'b01, 4'hF, 1);
    step(1, 2'b11, 4'hA, 1);
    // R3 load then R2 hold with data/fill toggling (R7, R8)
    step(0, 2'b01, 4'b1011, 0);
    step(0, 2'b00, 4'b0000, 1);
    step(0, 2'b00, 4'b0101, 0);
    // R4 invert twice
    step(0, 2'b10, 4'hF, 1);
    step(0, 2'b10, 4'h0, 1);
    // R5 shift out a 1 from bit 3, alternating fill
    step(0, 2'b11, 4'h0, 0);
    step(0, 2'b11, 4'hF, 1);
    step(0, 2'b11, 4'h0, 0);
    step(0, 2'b11, 4'hF, 1);
    step(0, 2'b11, 4'h0, 1);
    // load all ones, invert, shift ones in
    step(0, 2'b01, 4'hF, 0);
    step(0, 2'b10, 4'h5, 1);
    step(0, 2'b11, 4'h0, 1);
    // R1 reset overriding invert on a nonzero word
    step(0, 2'b01, 4'h9, 0);
    step(1, 2'b10, 4'h9, 1);
    // mixed pseudo-random run
    for (int i = 0; i < 2000; i++) begin
      int unsigned rv = $urandom;
      step((rv[7:0] == 8'd0), rv[9:8], rv[13:10], rv[14]);
    end
    step(0, 2'b00, 4'h0, 0);
    @(negedge clk);
    checkOut();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule